// File: doc/BRIEF.md
# Entropy Bit Collection Controller

This block gathers a programmable number of random bits from a single-bit entropy source input and holds them in eight 32-bit result words that software reads over a simple register bus. Software sets a sampling period (clock cycles between captured source bits), chooses a collection length and a source speed code, enables the source and then sets a start flag. While the flag reads 1 a collection is running. The hardware clears the flag itself once the last bit has been captured, so software polls it to learn that the result words are complete.

The control register takes a half-word write mask: the upper 16 bits of the write data select which of the lower 16 control bits the write updates. The register bus has no back-pressure. Every access that has `bus_valid` high completes in the cycle it is presented. Read data comes back combinationally in that same cycle. Writes take effect at the next clock edge.

Top module: `entropy_collector`

## Requirements
- R1: A write to the control register (byte offset 0x400) updates control bit i (0..15) only when write-data bit 16+i is 1. Every other control bit keeps its value. The control register reads back with bits [31:16] as zero.
- R2: Control bits [5:4] select the collection length: code 0 collects 64 bits, 1 collects 128, 2 collects 192 and 3 collects 256. With an effective period P, start (control bit 0) reads 0 again exactly N*P clock edges after the edge that launched the run, where N is the selected length.
- R3: Control bits [3:2] drive `osc_speed` unchanged. Control bit 1 (enable) drives `src_enable`.
- R4: A write that sets start while the resulting enable bit is 0 has no effect, and start reads back as 0.
- R5: Setting start again while a collection is running neither restarts it nor moves its completion time.
- R6: The sample-period register (offset 0x404, 16 bits, reset value 1000) sets the clock cycles between captures. The first capture happens P edges after the launch edge. A value of 0 acts as 1.
- R7: Captured bit k (k counted from 0) is stored in result word k/32 at bit position k%32. All result words are cleared when a run is launched, so words beyond the selected length read as zero after the run.
- R8: Writing 0x0000 to all control bits under a full mask (write data 0xFFFF0000) clears the whole control register and abandons the collection. After that the result words stop changing.
- R9: Result word j reads at offset 0x410+4*j (j = 0..7) and cannot be written. A read of any unmapped offset returns zero.
- R10: After reset the control register and all result words read 0 and the sample-period register reads 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data; upper half is the control write mask |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| src_bit | input | 1 | Bit from the entropy source |
| src_enable | output | 1 | Enable for the entropy source |
| osc_speed | output | 2 | Speed code passed to the entropy source |

## Verification
The assertions assume that software leaves the sample period and the length code alone while a collection is running. The capture spacing and the completion count are both measured against the values held in those registers. They also assume that `src_bit` and the bus inputs are always 0 or 1 and are stable around the clock edge. The stimulus meets these conditions by driving every input on the falling edge. It reprograms the period and length only while start reads 0, apart from the deliberate start re-write and the full-mask stop write.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int CTRL_OFS   = 'h400;
  localparam int PERIOD_OFS = 'h404;
  localparam int DATA_OFS   = 'h410;

  localparam int START_BIT  = 0;
  localparam int EN_BIT     = 1;
  localparam int SPEED_LO   = 2;
  localparam int LEN_LO     = 4;

  typedef enum logic [1:0] {
    LEN_Q1 = 2'd0,
    LEN_Q2 = 2'd1,
    LEN_Q3 = 2'd2,
    LEN_Q4 = 2'd3
  } len_code_e;
endpackage

// File: rtl/ecc_ctrl_reg.sv
module ecc_ctrl_reg
  import ecc_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2*CTRL_W-1:0] wdata,
  input  logic                done,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic                launch
);
  logic [CTRL_W-1:0] merged;
  logic [CTRL_W-1:0] ctrl_d;
  logic              start_d;

  // Apply the half-word mask bit by bit.
  always_comb begin
    merged = ctrl_q;
    for (int i = 0; i < CTRL_W; i++) begin
      if (wr_en && wdata[CTRL_W+i]) merged[i] = wdata[i];
    end
  end

  // Start: cleared on completion or loss of enable, held while busy,
  // set only by a masked write with enable in force.
  always_comb begin
    if (done || !merged[EN_BIT])  start_d = 1'b0;
    else if (ctrl_q[START_BIT])   start_d = 1'b1;
    else                          start_d = wr_en && wdata[CTRL_W+START_BIT] && wdata[START_BIT];
    ctrl_d            = merged;
    ctrl_d[START_BIT] = start_d;
  end

  assign launch = start_d && !ctrl_q[START_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/ecc_period_timer.sv
module ecc_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                launch,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] remain_q;
  logic [PERIOD_W-1:0] period_eff;

  assign period_eff = (period == '0) ? PERIOD_W'(1) : period;
  assign tick       = run && (remain_q == PERIOD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain_q <= '0;
    else if (launch) remain_q <= period_eff;
    else if (run)    remain_q <= tick ? period_eff : remain_q - PERIOD_W'(1);
  end
endmodule

// File: rtl/ecc_bit_accum.sv
module ecc_bit_accum #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int MAX_BITS = WORDS * WORD_W,
  localparam int IDX_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                tick,
  input  logic                src_bit,
  input  logic [IDX_W-1:0]    total_bits,
  output logic [MAX_BITS-1:0] bits,
  output logic [IDX_W-1:0]    bit_count,
  output logic                done
);
  assign done = tick && (bit_count == total_bits - IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_count <= '0;
    else if (launch) bit_count <= '0;
    else if (tick)   bit_count <= bit_count + IDX_W'(1);
  end

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 bits[g] <= 1'b0;
      else if (launch)                            bits[g] <= 1'b0;
      else if (tick && bit_count == IDX_W'(g))    bits[g] <= src_bit;
    end
  end
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
  import ecc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int WORDS      = 8,
  parameter int PERIOD_W   = 16,
  parameter int PERIOD_RST = 1000,
  parameter int LEN_CODES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              src_bit,
  output logic              src_enable,
  output logic [1:0]        osc_speed
);
  localparam int CTRL_W   = WORD_W / 2;
  localparam int MAX_BITS = WORDS * WORD_W;
  localparam int LEN_STEP = MAX_BITS / LEN_CODES;
  localparam int IDX_W    = $clog2(MAX_BITS + 1);

  logic [CTRL_W-1:0]   ctrl_q;
  logic [PERIOD_W-1:0] period_q;
  logic                launch, tick, done;
  logic [MAX_BITS-1:0] bits;
  logic [IDX_W-1:0]    bit_count;
  logic [IDX_W-1:0]    total_bits;
  logic                wr_ctrl, wr_period, rd_en;
  logic [WORD_W-1:0]   word_rd [WORDS];

  assign wr_ctrl   = bus_valid && bus_write && (bus_addr == ADDR_W'(CTRL_OFS));
  assign wr_period = bus_valid && bus_write && (bus_addr == ADDR_W'(PERIOD_OFS));
  assign rd_en     = bus_valid && !bus_write;

  assign total_bits = IDX_W'(LEN_STEP) * (IDX_W'(ctrl_q[LEN_LO +: 2]) + IDX_W'(1));
  assign osc_speed  = ctrl_q[SPEED_LO +: 2];
  assign src_enable = ctrl_q[EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         period_q <= PERIOD_W'(PERIOD_RST);
    else if (wr_period) period_q <= bus_wdata[PERIOD_W-1:0];
  end

  ecc_ctrl_reg #(.CTRL_W(CTRL_W)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ctrl),
    .wdata  (bus_wdata),
    .done   (done),
    .ctrl_q (ctrl_q),
    .launch (launch)
  );

  ecc_period_timer #(.PERIOD_W(PERIOD_W)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q[START_BIT]),
    .launch (launch),
    .period (period_q),
    .tick   (tick)
  );

  ecc_bit_accum #(.WORDS(WORDS), .WORD_W(WORD_W)) i_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .tick       (tick),
    .src_bit    (src_bit),
    .total_bits (total_bits),
    .bits       (bits),
    .bit_count  (bit_count),
    .done       (done)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_rd[w] = (bus_addr == ADDR_W'(DATA_OFS + 4 * w)) ? bits[w*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (bus_addr == ADDR_W'(CTRL_OFS))        bus_rdata = WORD_W'(ctrl_q);
      else if (bus_addr == ADDR_W'(PERIOD_OFS)) bus_rdata = WORD_W'(period_q);
      else begin
        for (int w = 0; w < WORDS; w++) bus_rdata = bus_rdata | word_rd[w];
      end
    end
  end
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker
  import ecc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 32,
  parameter int PERIOD_W = 16,
  parameter int MAX_BITS = 256,
  parameter int IDX_W    = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic [WORD_W-1:0]   bus_rdata,
  input logic                src_enable,
  input logic [WORD_W/2-1:0] ctrl_q,
  input logic [PERIOD_W-1:0] period_q,
  input logic                tick,
  input logic [IDX_W-1:0]    bit_count,
  input logic [IDX_W-1:0]    total_bits,
  input logic [MAX_BITS-1:0] bits
);
  logic [PERIOD_W:0] gap_q;
  logic [PERIOD_W:0] p_eff;
  logic              ctrl_wr, mapped;

  assign p_eff   = (period_q == '0) ? (PERIOD_W+1)'(1) : (PERIOD_W+1)'(period_q);
  assign ctrl_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(CTRL_OFS));
  assign mapped  = (bus_addr == ADDR_W'(CTRL_OFS)) || (bus_addr == ADDR_W'(PERIOD_OFS)) ||
                   ((bus_addr >= ADDR_W'(DATA_OFS)) && (bus_addr < ADDR_W'(DATA_OFS + MAX_BITS/8)) &&
                    (bus_addr[1:0] == 2'b00));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_q <= (PERIOD_W+1)'(1);
    else if (tick || !ctrl_q[0]) gap_q <= (PERIOD_W+1)'(1);
    else                        gap_q <= gap_q + (PERIOD_W+1)'(1);
  end

  // R1
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[WORD_W-1:WORD_W/2] == '0) |=> ctrl_q[WORD_W/2-1:1] == $past(ctrl_q[WORD_W/2-1:1]));

  // R2
  length_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_q[0]) && src_enable) |-> $past(bit_count) == $past(total_bits) - IDX_W'(1));

  // R4
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |-> ctrl_q[1]);

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && $past(ctrl_q[0])) |->
      (bit_count == $past(bit_count) || bit_count == $past(bit_count) + IDX_W'(1)));

  // R6
  period_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap_q == p_eff);

  // R7
  clear_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[0]) |-> bits == '0);

  // R8
  full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata == {{(WORD_W/2){1'b1}}, {(WORD_W/2){1'b0}}}) |=> ctrl_q == '0);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !mapped) |-> bus_rdata == '0);
endmodule

bind entropy_collector ecc_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PERIOD_W(PERIOD_W),
  .MAX_BITS(MAX_BITS), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .src_enable(src_enable), .ctrl_q(ctrl_q), .period_q(period_q), .tick(tick),
  .bit_count(bit_count), .total_bits(total_bits), .bits(bits)
);

// File: tb/test_entropy_collector.sv
module test_entropy_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        src_bit = 1'b0;
  logic        src_enable;
  logic [1:0]  osc_speed;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  logic [15:0]  m_ctrl;
  int           m_per;
  logic [255:0] m_data;
  int           m_cnt, m_tmr;
  logic [15:0]  nc;
  int           p, nbits;
  bit           old_start, done_now;

  entropy_collector i_entropy_collector (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_bit(src_bit), .src_enable(src_enable), .osc_speed(osc_speed)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    src_bit <= lfsr[0];
  end

  // behavioural model, one step per clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_per = 1000; m_data = '0; m_cnt = 0; m_tmr = 0;
    end else begin
      p = (m_per == 0) ? 1 : m_per;
      nbits = 64 * (int'(m_ctrl[5:4]) + 1);
      old_start = m_ctrl[0];
      done_now = 0;
      nc = m_ctrl;
      if (bus_valid && bus_write && bus_addr == 12'h400)
        for (int i = 0; i < 16; i++) if (bus_wdata[16+i]) nc[i] = bus_wdata[i];
      if (old_start) begin
        if (m_tmr == 1) begin
          m_data[m_cnt] = src_bit;
          m_cnt++;
          m_tmr = p;
          if (m_cnt == nbits) done_now = 1;
        end else m_tmr--;
      end
      if (done_now || !nc[1]) nc[0] = 1'b0;
      else if (old_start)     nc[0] = 1'b1;
      else nc[0] = bus_valid && bus_write && bus_addr == 12'h400 && bus_wdata[16] && bus_wdata[0];
      if (nc[0] && !old_start) begin m_data = '0; m_cnt = 0; m_tmr = p; end
      if (bus_valid && bus_write && bus_addr == 12'h404) m_per = int'(bus_wdata[15:0]);
      m_ctrl = nc;
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == 12'h400) return {16'h0, m_ctrl};
    if (a == 12'h404) return {16'h0, m_per[15:0]};
    for (int j = 0; j < 8; j++) if (a == 12'h410 + 12'(4*j)) return m_data[32*j +: 32];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the source-facing outputs (R3)
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      chk("R3 osc_speed", {30'h0, osc_speed}, {30'h0, m_ctrl[3:2]});
      chk("R3 src_enable", {31'h0, src_enable}, {31'h0, m_ctrl[1]});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_model(input logic [11:0] a, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, m_read(a));
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, e);
  endtask

  task automatic wait_idle(input int exp_cyc, input string tag);
    logic [31:0] d;
    for (int n = 0; n < 5000; n++) begin
      rd(12'h400, d);
      if (!d[0]) break;
    end
    chk(tag, 32'(cyc), 32'(exp_cyc));
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int c0;
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd_exp(12'h400, 32'h0, "R10 ctrl reset");
    rd_exp(12'h404, 32'd1000, "R10 period reset");
    rd_exp(12'h410, 32'h0, "R10 word0 reset");
    rd_exp(12'h408, 32'h0, "R9 unmapped read");

    // R3 fields
    wr(12'h404, 32'd3);
    wr(12'h400, 32'hFFFF_000A);
    rd_exp(12'h400, 32'h0000_000A, "R3 ctrl value");
    chk("R3 speed pin", {30'h0, osc_speed}, 32'd2);
    wr(12'h400, 32'h000C_0004);
    chk("R3 speed pin change", {30'h0, osc_speed}, 32'd1);
    wr(12'h400, 32'h000C_0008);

    // R1 masked writes
    wr(12'h400, 32'h0030_0010);
    rd_exp(12'h400, 32'h0000_001A, "R1 masked len");
    wr(12'h400, 32'h0000_FFFF);
    rd_exp(12'h400, 32'h0000_001A, "R1 empty mask");
    wr(12'h400, 32'h0030_0000);

    // R4 start without enable
    wr(12'h400, 32'h0003_0001);
    rd_exp(12'h400, 32'h0000_0008, "R4 start ignored");
    wr(12'h400, 32'h0002_0002);

    // R2 / R7: 64 bits at period 3
    wr(12'h400, 32'h0001_0001);
    c0 = cyc;
    wait_idle(c0 + 64*3, "R2 len64 timing");
    for (int j = 0; j < 8; j++) rd_model(12'h410 + 12'(4*j), "R7 word content");
    for (int j = 2; j < 8; j++) rd_exp(12'h410 + 12'(4*j), 32'h0, "R7 word beyond length");

    // R5: 128 bits at period 2, start rewritten mid-run
    wr(12'h404, 32'd2);
    wr(12'h400, 32'h0030_0010);
    wr(12'h400, 32'h0001_0001);
    c0 = cyc;
    repeat (40) @(negedge clk);
    wr(12'h400, 32'h0001_0001);
    wait_idle(c0 + 128*2, "R5 no restart");
    for (int j = 0; j < 8; j++) rd_model(12'h410 + 12'(4*j), "R7 word content len128");

    // R6: period 0 acts as 1, R2 length 256
    wr(12'h404, 32'd0);
    rd_exp(12'h404, 32'h0, "R6 period readback");
    wr(12'h400, 32'h0030_0030);
    wr(12'h400, 32'h0001_0001);
    c0 = cyc;
    wait_idle(c0 + 256, "R6 zero period len256");
    for (int j = 0; j < 8; j++) rd_model(12'h410 + 12'(4*j), "R7 word content len256");

    // R8: abandon a 192-bit run at period 5
    wr(12'h404, 32'd5);
    wr(12'h400, 32'h0030_0020);
    wr(12'h400, 32'h0001_0001);
    repeat (50) @(negedge clk);
    wr(12'h400, 32'hFFFF_0000);
    rd_exp(12'h400, 32'h0, "R8 stop clears ctrl");
    rd(12'h410, snap);
    chk("R8 partial word model", snap, m_read(12'h410));
    repeat (30) @(negedge clk);
    rd_exp(12'h410, snap, "R8 words frozen");

    // R9 read-only result and unmapped offsets
    wr(12'h410, 32'hFFFF_FFFF);
    rd_exp(12'h410, snap, "R9 result read-only");
    rd_exp(12'h430, 32'h0, "R9 past result area");
    rd_exp(12'h800, 32'h0, "R9 far unmapped");
    rd_exp(12'h412, 32'h0, "R9 misaligned");

    @(negedge clk);
    bus_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_sim();
  end
endmodule